// File: doc/BRIEF.md
# Shared-Ramp Multichannel Conversion Controller

This block is the digital back end of a single-slope converter in which one analog ramp and one Gray-coded counter serve many channels at once. It runs the conversion phases: a sample and offset-nulling window, a window in which the comparators are linked to the ramp while the ramp is still held at zero, and a counting window during which the ramp runs. Each channel's comparator output reaches the block as a digital trip line. When a channel trips, the block stores the counter value for that channel. A channel that never trips in a conversion stores the top code.

Every channel has two result stages. The first stage fills during counting. On entry to the next sample window, the first stage is copied into the second stage, and then the first stage is cleared. Software or a downstream reader picks a channel with a select input and sees that channel's second-stage result as plain binary. Sampling is tied to the upstream sample-and-hold. The block does not leave its idle phase, and it does not advance the sample window, while the upstream hold output is not valid.

The counter is kept as three copies. Each copy reloads from the bitwise majority of the three. No stream handshakes are present. The readout is a combinational select and has no back-pressure. All other pins are plain level controls.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: After synchronous reset the block is idle: `ramp_rst` is 1; `ics`, `az`, `ramp_link` and `cnt_run` are 0. The first result set copied to the second stage reads 0 on every channel.
- R2: While idle, the block stays idle as long as `hold_valid` is 0. The idle-to-sample step happens on the first edge with `hold_valid` 1. That same edge copies every channel's first-stage result into its second stage.
- R3: During the sample window, `az` and `ramp_rst` are 1, and `ics` equals `hold_valid`. The window ends after exactly SAMPLE_CYC cycles with `hold_valid` 1. Cycles with `hold_valid` 0 do not count toward the window.
- R4: The link window then lasts LINK_CYC cycles with `ramp_link` and `ramp_rst` at 1. It is followed by the count window, with `ramp_rst` at 0 and `cnt_run` and `ramp_link` at 1, for exactly 2^W cycles. The block then returns to idle.
- R5: Count cycles are numbered from 0. If a channel's trip line is sampled high in count cycle k, the channel stores count k. Only the first trip of a conversion is kept; later trips are ignored.
- R6: A channel whose trip line stays low for the whole count window stores full scale, 2^W-1.
- R7: Trip lines are ignored outside the count window.
- R8: `rd_code` is the binary value of the second-stage result of the channel given by `rd_sel`. It changes only on a copy into the second stage, and it stays steady through the following conversion.
- R9: The three counter copies always agree. The voted count moves by exactly one Gray step (one bit changes) on each count cycle, starting from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hold_valid | input | 1 | Upstream hold output is valid |
| trip | input | NCH | Per-channel comparator trip lines |
| rd_sel | input | max(1, clog2(NCH)) | Channel to read out |
| ics | output | 1 | Input sampling switch control |
| az | output | 1 | Comparator offset-nulling control |
| ramp_rst | output | 1 | Holds ramp integrator at zero |
| ramp_link | output | 1 | Connects comparators to the ramp |
| cnt_run | output | 1 | Count window active |
| rd_code | output | W | Binary result of the selected channel |

## Verification
A wrong phase state shows on the phase pins in the next cycle. Examples are a window one cycle too long or an early exit from idle while the hold output is invalid. A counter copy that slips, or a first-stage latch that takes a later trip or misses a clear, is hidden during the conversion. It shows only at the next copy into the second stage, as a result on `rd_code` that differs from the trip cycle driven. That is about one conversion after the fault. Readout values are re-read at the start of the next count window, so a second stage that changes outside a copy edge is caught before the next result lands.

// File: rtl/ramp_adc_pkg.sv
`timescale 1ns/1ps
package ramp_adc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_LINK   = 2'd2,
    PH_COUNT  = 2'd3
  } phase_e;

  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/adc_phase_seq.sv
`timescale 1ns/1ps
module adc_phase_seq
  import ramp_adc_pkg::*;
#(
  parameter int SAMPLE_CYC = 8,
  parameter int LINK_CYC   = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   hold_valid,
  input  logic   cnt_last,
  output phase_e phase,
  output logic   refresh,
  output logic   clr_first
);
  localparam int TMAX = (SAMPLE_CYC > LINK_CYC) ? SAMPLE_CYC : LINK_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] S_LAST = TW'(SAMPLE_CYC - 1);
  localparam logic [TW-1:0] L_LAST = TW'(LINK_CYC - 1);

  phase_e        st;
  logic [TW-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= PH_IDLE;
      tmr <= '0;
    end else begin
      unique case (st)
        PH_IDLE: if (hold_valid) begin
          st  <= PH_SAMPLE;
          tmr <= '0;
        end
        PH_SAMPLE: if (hold_valid) begin
          if (tmr == S_LAST) begin
            st  <= PH_LINK;
            tmr <= '0;
          end else tmr <= tmr + 1'b1;
        end
        PH_LINK: begin
          if (tmr == L_LAST) begin
            st  <= PH_COUNT;
            tmr <= '0;
          end else tmr <= tmr + 1'b1;
        end
        PH_COUNT: if (cnt_last) st <= PH_IDLE;
        default: st <= PH_IDLE;
      endcase
    end
  end

  assign phase     = st;
  assign refresh   = (st == PH_IDLE) && hold_valid;
  assign clr_first = (st == PH_SAMPLE) && (tmr == '0);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (st == PH_IDLE && !hold_valid) |=> (st == PH_IDLE));
  assert_sample_pause_R3: assert property (@(posedge clk) disable iff (rst)
    (st == PH_SAMPLE && !hold_valid) |=> (st == PH_SAMPLE && $stable(tmr)));
  assert_count_entry_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(st == PH_COUNT) |-> ($past(st) == PH_LINK));
  assert_count_exit_R4: assert property (@(posedge clk) disable iff (rst)
    (st == PH_COUNT && cnt_last) |=> (st == PH_IDLE));
endmodule

// File: rtl/tmr_gray_counter.sv
`timescale 1ns/1ps
module tmr_gray_counter
  import ramp_adc_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  output logic [W-1:0] voted,
  output logic         last
);
  localparam int NCOPY = 3;
  localparam logic [W-1:0] GRAY_TOP = W'(to_gray(32'((64'(1) << W) - 1)));

  logic [W-1:0] copy_q [NCOPY];
  logic [W-1:0] nxt;

  assign voted = (copy_q[0] & copy_q[1]) | (copy_q[0] & copy_q[2]) |
                 (copy_q[1] & copy_q[2]);
  assign nxt   = W'(to_gray(from_gray(32'(voted)) + 32'd1));
  assign last  = (voted == GRAY_TOP);

  always_ff @(posedge clk) begin
    for (int j = 0; j < NCOPY; j++) begin
      if (rst || !run) copy_q[j] <= '0;
      else             copy_q[j] <= nxt;
    end
  end

  assert_copies_agree_R9: assert property (@(posedge clk) disable iff (rst)
    (copy_q[0] == copy_q[1]) && (copy_q[1] == copy_q[2]));
  assert_gray_step_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && !$past(last)) |-> ($countones(voted ^ $past(voted)) == 1));
endmodule

// File: rtl/adc_chan_latch.sv
`timescale 1ns/1ps
module adc_chan_latch #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         count_en,
  input  logic         last,
  input  logic         clr_first,
  input  logic         refresh,
  input  logic         trip,
  input  logic [W-1:0] code,
  output logic [W-1:0] held
);
  logic [W-1:0] first_q;
  logic         got_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= '0;
      got_q   <= 1'b0;
      held    <= '0;
    end else begin
      if (refresh) held <= first_q;
      if (clr_first) begin
        first_q <= '0;
        got_q   <= 1'b0;
      end else if (count_en && !got_q && (trip || last)) begin
        first_q <= code;
        got_q   <= 1'b1;
      end
    end
  end

  assert_first_only_R5: assert property (@(posedge clk) disable iff (rst)
    (got_q && !clr_first) |=> $stable(first_q));
  assert_second_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !refresh |=> $stable(held));
endmodule

// File: rtl/ramp_adc_ctrl.sv
`timescale 1ns/1ps
module ramp_adc_ctrl
  import ramp_adc_pkg::*;
#(
  parameter int NCH        = 16,
  parameter int W          = 12,
  parameter int SAMPLE_CYC = 8,
  parameter int LINK_CYC   = 4
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  hold_valid,
  input  logic [NCH-1:0]                        trip,
  input  logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] rd_sel,
  output logic                                  ics,
  output logic                                  az,
  output logic                                  ramp_rst,
  output logic                                  ramp_link,
  output logic                                  cnt_run,
  output logic [W-1:0]                          rd_code
);
  localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1;

  phase_e       phase;
  logic         refresh, clr_first, cnt_last, counting;
  logic [W-1:0] code;
  logic [W-1:0] held [NCH];

  adc_phase_seq #(.SAMPLE_CYC(SAMPLE_CYC), .LINK_CYC(LINK_CYC)) u_seq (
    .clk(clk), .rst(rst), .hold_valid(hold_valid), .cnt_last(cnt_last),
    .phase(phase), .refresh(refresh), .clr_first(clr_first)
  );

  assign counting = (phase == PH_COUNT);

  tmr_gray_counter #(.W(W)) u_ctr (
    .clk(clk), .rst(rst), .run(counting), .voted(code), .last(cnt_last)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    adc_chan_latch #(.W(W)) u_lat (
      .clk(clk), .rst(rst), .count_en(counting), .last(cnt_last),
      .clr_first(clr_first), .refresh(refresh), .trip(trip[c]),
      .code(code), .held(held[c])
    );
  end

  assign ics       = (phase == PH_SAMPLE) && hold_valid;
  assign az        = (phase == PH_SAMPLE);
  assign ramp_rst  = (phase != PH_COUNT);
  assign ramp_link = (phase == PH_LINK) || counting;
  assign cnt_run   = counting;

  always_comb begin
    rd_code = '0;
    for (int c = 0; c < NCH; c++)
      if (rd_sel == SELW'(c)) rd_code = W'(from_gray(32'(held[c])));
  end
endmodule

// File: tb/ramp_adc_ctrl_test.sv
`timescale 1ns/1ps
module ramp_adc_ctrl_test;
  localparam int NCH = 4;
  localparam int W   = 6;
  localparam int SC  = 4;
  localparam int LC  = 3;
  localparam int TOP = (1 << W) - 1;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           hold_valid = 1'b0;
  logic [NCH-1:0] trip = '0;
  logic [1:0]     rd_sel;
  logic           ics, az, ramp_rst, ramp_link, cnt_run;
  logic [W-1:0]   rd_code;

  int    checks = 0;
  int    fails  = 0;
  int    exp_q[$];
  string tag_q[$];

  ramp_adc_ctrl #(.NCH(NCH), .W(W), .SAMPLE_CYC(SC), .LINK_CYC(LC)) uut (
    .clk(clk), .rst(rst), .hold_valid(hold_valid), .trip(trip),
    .rd_sel(rd_sel), .ics(ics), .az(az), .ramp_rst(ramp_rst),
    .ramp_link(ramp_link), .cnt_run(cnt_run), .rd_code(rd_code)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // t >= 0: trip pulses at count cycle t and t+2; -1: never; -2: high only outside counting
  task automatic drive_trip(input int t[NCH], input bit counting, input int k);
    for (int i = 0; i < NCH; i++) begin
      if (t[i] == -2) trip[i] = !counting;
      else if (t[i] >= 0) trip[i] = counting && (k == t[i] || k == t[i] + 2);
      else trip[i] = 1'b0;
    end
  endtask

  task automatic run_conv(input int t[NCH], input int gap);
    int n, m, k, g;
    for (int i = 0; i < NCH; i++) begin
      exp_q.push_back((t[i] >= 0) ? t[i] : TOP);
      tag_q.push_back((t[i] >= 0) ? "R5 R9" : ((t[i] == -1) ? "R6" : "R7"));
    end
    drive_trip(t, 1'b0, 0);
    hold_valid = 1'b0;
    repeat (3) begin
      @(negedge clk); #1;
      check("R2 idle while hold invalid", {az, ramp_rst}, 2'b01);
    end
    @(negedge clk);
    hold_valid = 1'b1;
    @(negedge clk);
    check("R3 sample entered", az, 1);
    n = 0; g = 0;
    while (az) begin
      if (g < gap) begin
        hold_valid = 1'b0; #1;
        check("R3 ics low without hold", ics, 0);
        g++;
      end else begin
        hold_valid = 1'b1; #1;
        check("R3 ics with hold", ics, 1);
        n++;
      end
      @(negedge clk);
    end
    check("R3 sample length", n, SC);
    m = 0;
    while (ramp_link && !cnt_run) begin
      if (!ramp_rst) check("R4 ramp held in link", ramp_rst, 1);
      m++;
      @(negedge clk);
    end
    check("R4 link length", m, LC);
    k = 0;
    while (cnt_run) begin
      if (k == 0) check("R4 ramp released", {ramp_rst, ramp_link}, 2'b01);
      drive_trip(t, 1'b1, k);
      k++;
      @(negedge clk);
    end
    check("R4 count length", k, TOP + 1);
    drive_trip(t, 1'b0, 0);
    hold_valid = 1'b0;
  endtask

  // Monitor: scoreboard compare on each copy into the second stage
  initial begin
    int  last_rd[NCH];
    bit  prev_az = 1'b0, prev_run = 1'b0;
    rd_sel = '0;
    forever begin
      @(negedge clk);
      if (!rst && az && !prev_az) begin
        for (int i = 0; i < NCH; i++) begin
          rd_sel = 2'(i); #0.5;
          if (exp_q.size() == 0) check("R8 unexpected result", 1, 0);
          else begin
            automatic int    e  = exp_q.pop_front();
            automatic string tg = tag_q.pop_front();
            check($sformatf("%s R8 ch%0d", tg, i), int'(rd_code), e);
          end
          last_rd[i] = int'(rd_code);
        end
      end
      if (!rst && cnt_run && !prev_run) begin
        for (int i = 0; i < NCH; i++) begin
          rd_sel = 2'(i); #0.5;
          check($sformatf("R8 stable ch%0d", i), int'(rd_code), last_rd[i]);
        end
      end
      prev_az  = az;
      prev_run = cnt_run;
    end
  end

  initial begin
    #(8 * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset phase pins", {ics, az, ramp_rst, ramp_link, cnt_run}, 5'b00100);
    rst = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      exp_q.push_back(0);
      tag_q.push_back("R1");
    end
    run_conv('{17, 0, 63, -1}, 2);
    run_conv('{42, -2, 5, 63}, 0);
    run_conv('{1, 30, -1, -2}, 1);
    @(negedge clk);
    hold_valid = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule